// File: doc/BRIEF.md
# Cumulative Histogram Statistics Extractor

This block sits behind a histogram engine that keeps a cumulative count per bin, so bin `i` holds the number of samples whose bin index is at most `i`. On a request it takes a snapshot of the whole count vector, together with two bin indices, the window size and a centile threshold. From that snapshot it computes three probability figures and one centile position. All counts are raw integers. Normalising by the window size is left to the user.

The probability path selects the counts of bins `a` and `b` through run-time multiplexers. It returns the count at `a`, the window size less that count, and the count at `b` less the count at `a`. The centile path compares every bin with the threshold in parallel. Because the counts never decrease with the bin index, the compare flags form a thermometer code. A two-level pipelined tree of small lowest-index encoders then finds the first flagged bin. The two paths share the snapshot but have different latencies. Each path has its own valid strobe.

Top module: `cdf_query_unit`

## Requirements
- R1: `p_below_o` equals the count of bin `idx_a_i`. Bin `i` occupies bits `[i*CNT_W +: CNT_W]` of `counts_i`.
- R2: `p_above_o` equals `win_size_i` minus the count of bin `idx_a_i`, modulo 2^CNT_W.
- R3: `p_range_o` equals the count of bin `idx_b_i` minus the count of bin `idx_a_i`, modulo 2^CNT_W.
- R4: `cent_idx_o` is the lowest bin index whose count is greater than or equal to `thresh_i`. A count equal to the threshold qualifies. A threshold of zero gives index 0.
- R5: When no bin reaches the threshold, `cent_none_o` is 1 and `cent_idx_o` is 0. Otherwise `cent_none_o` is 0.
- R6: A request is sampled on the rising edge at which `in_valid_i` is 1. The probability results and `prob_valid_o` appear after the next rising edge. The centile results and `cent_valid_o` appear three rising edges after the sampling edge.
- R7: All inputs are sampled only on a request edge. Values present while `in_valid_i` is 0 do not change any result, and they produce no valid strobe.
- R8: While `rst_n` is low, both valid strobes are 0 and all result outputs are 0.
- R9: Requests may arrive on consecutive cycles. Each one produces exactly one result on each path, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Request strobe; samples all other inputs |
| counts_i | input | NUM_BINS*CNT_W | Cumulative bin counts, bin 0 in the low bits |
| idx_a_i | input | IDX_W | Bin index a |
| idx_b_i | input | IDX_W | Bin index b |
| win_size_i | input | CNT_W | Window size in samples |
| thresh_i | input | CNT_W | Centile threshold as a sample count |
| prob_valid_o | output | 1 | Probability results valid |
| p_below_o | output | CNT_W | Count of bin a |
| p_above_o | output | CNT_W | Window size minus count of bin a |
| p_range_o | output | CNT_W | Count of bin b minus count of bin a |
| cent_valid_o | output | 1 | Centile result valid |
| cent_idx_o | output | IDX_W | Lowest bin meeting the threshold |
| cent_none_o | output | 1 | No bin meets the threshold |

## Verification
The bench targets these corner cases:
- **Plateaus.** Equal counts across several bins make an equality-versus-strict compare error move the centile by whole bins.
- **Thresholds next to a bin count.** Thresholds one below, equal to and one above a bin's count catch an off-by-one compare.
- **Found in the highest group.** When the only qualifying bins lie in the top encoder group, a wrong group-select or a highest-index encoder returns the wrong half of the index.
- **Nothing qualifies.** Thresholds above the top count, and an all-zero vector, expose a missing not-found flag or a stale index.
- **Wrapping results.** Subtractions with `b` below `a`, or a window smaller than a count, show whether the results wrap or saturate.
- **Timing and snapshot.** Back-to-back requests interleaved with junk on idle cycles reveal a pipeline that mixes snapshots, drops slots or strobes on its own.

// File: rtl/cdf_stat_pkg.sv
package cdf_stat_pkg;

    // Index width for n items; at least one bit.
    function automatic int idx_bits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cdf_first_set.sv
module cdf_first_set
    import cdf_stat_pkg::*;
#(
    parameter int W  = 4,
    parameter int IW = idx_bits(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    // Lowest set position wins: scan downward so the last hit is the lowest.
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end

endmodule

// File: rtl/cdf_range_path.sv
module cdf_range_path
    import cdf_stat_pkg::*;
#(
    parameter int NUM_BINS = 16,
    parameter int CNT_W    = 8,
    parameter int IDX_W    = idx_bits(NUM_BINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      snap_valid_i,
    input  logic [NUM_BINS*CNT_W-1:0] snap_counts_i,
    input  logic [IDX_W-1:0]          snap_a_i,
    input  logic [IDX_W-1:0]          snap_b_i,
    input  logic [CNT_W-1:0]          snap_win_i,
    output logic                      valid_o,
    output logic [CNT_W-1:0]          below_o,
    output logic [CNT_W-1:0]          above_o,
    output logic [CNT_W-1:0]          range_o
);

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] below;
        logic [CNT_W-1:0] above;
        logic [CNT_W-1:0] range;
    } res_t;

    res_t res_d, res_q;
    logic [CNT_W-1:0] cnt_a, cnt_b;

    always_comb begin
        cnt_a       = snap_counts_i[snap_a_i * CNT_W +: CNT_W];
        cnt_b       = snap_counts_i[snap_b_i * CNT_W +: CNT_W];
        res_d       = res_q;
        res_d.valid = snap_valid_i;
        if (snap_valid_i) begin
            res_d.below = cnt_a;
            res_d.above = snap_win_i - cnt_a;
            res_d.range = cnt_b - cnt_a;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign valid_o = res_q.valid;
    assign below_o = res_q.below;
    assign above_o = res_q.above;
    assign range_o = res_q.range;

endmodule

// File: rtl/cdf_centile_path.sv
module cdf_centile_path
    import cdf_stat_pkg::*;
#(
    parameter int NUM_BINS = 16,
    parameter int CNT_W    = 8,
    parameter int GRP      = 4,
    parameter int IDX_W    = idx_bits(NUM_BINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      snap_valid_i,
    input  logic [NUM_BINS*CNT_W-1:0] snap_counts_i,
    input  logic [CNT_W-1:0]          snap_thresh_i,
    output logic                      valid_o,
    output logic [IDX_W-1:0]          idx_o,
    output logic                      none_o
);

    localparam int NGRP  = NUM_BINS / GRP;
    localparam int GW    = idx_bits(GRP);
    localparam int SEL_W = idx_bits(NGRP);

    typedef struct packed {
        // stage 1: thermometer flags
        logic                      s1_valid;
        logic [NUM_BINS-1:0]       flags;
        // stage 2: per-group encoders
        logic                      s2_valid;
        logic [NGRP-1:0]           grp_any;
        logic [NGRP-1:0][GW-1:0]   grp_idx;
        // stage 3: result
        logic                      s3_valid;
        logic [IDX_W-1:0]          idx;
        logic                      none;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [NGRP-1:0]         grp_any_w;
    logic [NGRP-1:0][GW-1:0] grp_idx_w;
    logic                    top_any_w;
    logic [SEL_W-1:0]        top_sel_w;

    // First level: one small encoder per group of GRP bins.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        cdf_first_set #(.W(GRP), .IW(GW)) u_enc (
            .vec_i (pipe_q.flags[g*GRP +: GRP]),
            .any_o (grp_any_w[g]),
            .idx_o (grp_idx_w[g])
        );
    end

    // Second level: picks the lowest group with any flag.
    cdf_first_set #(.W(NGRP), .IW(SEL_W)) u_top (
        .vec_i (pipe_q.grp_any),
        .any_o (top_any_w),
        .idx_o (top_sel_w)
    );

    always_comb begin
        pipe_d          = pipe_q;
        pipe_d.s1_valid = snap_valid_i;
        pipe_d.s2_valid = pipe_q.s1_valid;
        pipe_d.s3_valid = pipe_q.s2_valid;
        if (snap_valid_i) begin
            for (int i = 0; i < NUM_BINS; i++) begin
                pipe_d.flags[i] = snap_counts_i[i*CNT_W +: CNT_W] >= snap_thresh_i;
            end
        end
        if (pipe_q.s1_valid) begin
            pipe_d.grp_any = grp_any_w;
            pipe_d.grp_idx = grp_idx_w;
        end
        if (pipe_q.s2_valid) begin
            pipe_d.none = !top_any_w;
            pipe_d.idx  = top_any_w ? IDX_W'({top_sel_w, pipe_q.grp_idx[top_sel_w]}) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign valid_o = pipe_q.s3_valid;
    assign idx_o   = pipe_q.idx;
    assign none_o  = pipe_q.none;

endmodule

// File: rtl/cdf_query_unit.sv
module cdf_query_unit
    import cdf_stat_pkg::*;
#(
    parameter  int NUM_BINS = 16,
    parameter  int CNT_W    = 8,
    parameter  int GRP      = 4,
    localparam int IDX_W    = idx_bits(NUM_BINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid_i,
    input  logic [NUM_BINS*CNT_W-1:0] counts_i,
    input  logic [IDX_W-1:0]          idx_a_i,
    input  logic [IDX_W-1:0]          idx_b_i,
    input  logic [CNT_W-1:0]          win_size_i,
    input  logic [CNT_W-1:0]          thresh_i,
    output logic                      prob_valid_o,
    output logic [CNT_W-1:0]          p_below_o,
    output logic [CNT_W-1:0]          p_above_o,
    output logic [CNT_W-1:0]          p_range_o,
    output logic                      cent_valid_o,
    output logic [IDX_W-1:0]          cent_idx_o,
    output logic                      cent_none_o
);

    typedef struct packed {
        logic                      valid;
        logic [NUM_BINS*CNT_W-1:0] counts;
        logic [IDX_W-1:0]          a;
        logic [IDX_W-1:0]          b;
        logic [CNT_W-1:0]          win;
        logic [CNT_W-1:0]          thresh;
    } snap_t;

    snap_t snap_d, snap_q;

    // One snapshot feeds both paths, so every result of a slot agrees.
    always_comb begin
        snap_d       = snap_q;
        snap_d.valid = in_valid_i;
        if (in_valid_i) begin
            snap_d.counts = counts_i;
            snap_d.a      = idx_a_i;
            snap_d.b      = idx_b_i;
            snap_d.win    = win_size_i;
            snap_d.thresh = thresh_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    cdf_range_path #(.NUM_BINS(NUM_BINS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_range (
        .clk           (clk),
        .rst_n         (rst_n),
        .snap_valid_i  (snap_q.valid),
        .snap_counts_i (snap_q.counts),
        .snap_a_i      (snap_q.a),
        .snap_b_i      (snap_q.b),
        .snap_win_i    (snap_q.win),
        .valid_o       (prob_valid_o),
        .below_o       (p_below_o),
        .above_o       (p_above_o),
        .range_o       (p_range_o)
    );

    cdf_centile_path #(.NUM_BINS(NUM_BINS), .CNT_W(CNT_W), .GRP(GRP), .IDX_W(IDX_W)) u_cent (
        .clk           (clk),
        .rst_n         (rst_n),
        .snap_valid_i  (snap_q.valid),
        .snap_counts_i (snap_q.counts),
        .snap_thresh_i (snap_q.thresh),
        .valid_o       (cent_valid_o),
        .idx_o         (cent_idx_o),
        .none_o        (cent_none_o)
    );

endmodule

// File: rtl/cdf_query_unit_chk.sv
module cdf_query_unit_chk #(
    parameter int NUM_BINS = 16,
    parameter int CNT_W    = 8,
    parameter int IDX_W    = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid_i,
    input logic [CNT_W-1:0]          win_size_i,
    input logic                      prob_valid_o,
    input logic [CNT_W-1:0]          p_below_o,
    input logic [CNT_W-1:0]          p_above_o,
    input logic                      cent_valid_o,
    input logic [IDX_W-1:0]          cent_idx_o,
    input logic                      cent_none_o
);

    assert_prob_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> ##1 prob_valid_o);

    assert_cent_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> ##3 cent_valid_o);

    assert_no_spurious_prob_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ##1 !prob_valid_o);

    assert_none_zero_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cent_valid_o && cent_none_o) |-> (cent_idx_o == '0));

    assert_above_plus_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prob_valid_o |-> (CNT_W'(p_above_o + p_below_o) == $past(win_size_i, 2)));

endmodule

bind cdf_query_unit cdf_query_unit_chk #(.NUM_BINS(NUM_BINS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid_i   (in_valid_i),
    .win_size_i   (win_size_i),
    .prob_valid_o (prob_valid_o),
    .p_below_o    (p_below_o),
    .p_above_o    (p_above_o),
    .cent_valid_o (cent_valid_o),
    .cent_idx_o   (cent_idx_o),
    .cent_none_o  (cent_none_o)
);

// File: tb/cdf_query_unit_test.sv
module cdf_query_unit_test;

    localparam int NB    = 16;
    localparam int CW    = 8;
    localparam int IW    = 4;
    localparam int MAXQ  = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid_i = 1'b0;
    logic [NB*CW-1:0]  counts_i = '0;
    logic [IW-1:0]     idx_a_i = '0, idx_b_i = '0;
    logic [CW-1:0]     win_size_i = '0, thresh_i = '0;
    logic              prob_valid_o, cent_valid_o, cent_none_o;
    logic [CW-1:0]     p_below_o, p_above_o, p_range_o;
    logic [IW-1:0]     cent_idx_o;

    cdf_query_unit #(.NUM_BINS(NB), .CNT_W(CW), .GRP(4)) uut (.*);

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0, errors = 0, cyc = 0;
    int wr = 0, rd_p = 0, rd_c = 0;
    int          q_issue [MAXQ];
    logic [CW-1:0] q_below [MAXQ], q_above [MAXQ], q_range [MAXQ];
    logic [IW-1:0] q_idx [MAXQ];
    logic          q_none [MAXQ];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monotonic count patterns.
    function automatic int cnt_of(input int v, input int i);
        case (v)
            0: return 0;
            1: return i * 16 + 5;
            2: return (i / 4) * 60;
            3: return 255;
            4: return (i < 13) ? 0 : 200;
            default: return i + 100;
        endcase
    endfunction

    function automatic int win_of(input int v);
        case (v)
            0: return 255; 1: return 250; 2: return 100; 3: return 255; 4: return 200;
            default: return 7;
        endcase
    endfunction

    // Result monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && prob_valid_o) begin
            if (rd_p >= wr) chk(1'b0, "R9 unexpected prob_valid", 1, 0);
            else begin
                chk(cyc == q_issue[rd_p] + 1, "R6 prob latency", cyc, q_issue[rd_p] + 1);
                chk(p_below_o == q_below[rd_p], "R1 p_below", p_below_o, q_below[rd_p]);
                chk(p_above_o == q_above[rd_p], "R2 p_above", p_above_o, q_above[rd_p]);
                chk(p_range_o == q_range[rd_p], "R3 p_range", p_range_o, q_range[rd_p]);
                rd_p++;
            end
        end
        if (rst_n && cent_valid_o) begin
            if (rd_c >= wr) chk(1'b0, "R9 unexpected cent_valid", 1, 0);
            else begin
                chk(cyc == q_issue[rd_c] + 3, "R6 centile latency", cyc, q_issue[rd_c] + 3);
                chk(cent_idx_o == q_idx[rd_c], "R4 centile index", cent_idx_o, q_idx[rd_c]);
                chk(cent_none_o == q_none[rd_c], "R5 not-found flag", cent_none_o, q_none[rd_c]);
                rd_c++;
            end
        end
    end

    task automatic issue(input int v, input int a, input int b, input int th);
        int ca, cb, ex_i;
        bit found;
        @(negedge clk);
        for (int i = 0; i < NB; i++) counts_i[i*CW +: CW] = CW'(cnt_of(v, i));
        idx_a_i    = IW'(a);
        idx_b_i    = IW'(b);
        win_size_i = CW'(win_of(v));
        thresh_i   = CW'(th);
        in_valid_i = 1'b1;
        ca = cnt_of(v, a);
        cb = cnt_of(v, b);
        found = 1'b0; ex_i = 0;
        for (int i = NB - 1; i >= 0; i--) if (cnt_of(v, i) >= th) begin found = 1'b1; ex_i = i; end
        q_issue[wr] = cyc + 1;
        q_below[wr] = CW'(ca);
        q_above[wr] = CW'(win_of(v) - ca);
        q_range[wr] = CW'(cb - ca);
        q_idx[wr]   = IW'(ex_i);
        q_none[wr]  = !found;
        wr++;
    endtask

    // Idle cycle with junk on every data input (R7).
    task automatic idle_junk(input int seed);
        @(negedge clk);
        in_valid_i = 1'b0;
        for (int i = 0; i < NB; i++) counts_i[i*CW +: CW] = CW'(seed * 37 + i * 11);
        idx_a_i = IW'(seed); idx_b_i = IW'(seed + 7);
        win_size_i = CW'(seed * 3); thresh_i = CW'(seed * 5 + 1);
    endtask

    initial begin
        int n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!prob_valid_o && !cent_valid_o, "R8 valids low in reset", prob_valid_o, 0);
        chk(p_below_o == 0 && p_above_o == 0 && p_range_o == 0, "R8 prob outputs zero in reset",
            p_below_o, 0);
        chk(cent_idx_o == 0 && !cent_none_o, "R8 centile outputs zero in reset", cent_idx_o, 0);
        rst_n = 1'b1;
        for (int v = 0; v < 6; v++) begin
            for (int a = 0; a < NB; a++) begin
                for (int b = 0; b < NB; b++) begin
                    int th, k;
                    k = (a + b) % NB;
                    case (b % 4)
                        0: th = cnt_of(v, k);
                        1: th = cnt_of(v, k) + 1;
                        2: th = (cnt_of(v, k) > 0) ? cnt_of(v, k) - 1 : 0;
                        default: th = (a % 2) ? 255 : 0;
                    endcase
                    if (th > 255) th = 255;
                    issue(v, a, b, th);      // R4 R5 R9: back-to-back sweep
                    n++;
                    if (n % 7 == 3) idle_junk(n);
                end
            end
        end
        idle_junk(999);
        repeat (8) @(negedge clk);
        chk(rd_p == wr, "R9 all prob results delivered", rd_p, wr);
        chk(rd_c == wr, "R9 all centile results delivered", rd_c, wr);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule